// File: doc/BRIEF.md
# Three-Port Parallel I/O Block with Command-Word Configuration

This block gives a host 24 general-purpose lines arranged as two byte-wide ports (A and B) and a third byte-wide port C whose two nibbles are configured separately. The host reaches the block through a small register bus. A 2-bit offset selects port A, port B, port C or the control register. Reads and writes are qualified by separate strobes. Each line has an output value and an output-enable pin, so a tri-state pad can be attached outside the block.

The control register is write-only and accepts two kinds of command, chosen by the top bit of the written byte. A configuration word sets the direction of port A, port B and each nibble of port C, and records the handshake mode requested for each group. A single-bit command sets or clears one line of the port C output latch. Only simple I/O is carried out: written output data is held in latches, and input ports return the live pin values. The requested group modes are only reported on the mode pins.

The host bus is a plain register interface with no back-pressure. A write takes effect at the clock edge on which the write strobe is sampled high. Read data is combinational from the offset while the read strobe is high and is zero otherwise. There is no valid/ready stream at the edge of this block.

Top module: `pio_triport`

## Requirements
- R1: After reset every output-enable pin is 0 (all lines are inputs), every output latch reads 0, and both mode outputs are 0.
- R2: A write to offset 3 with bit 7 = 1 is a configuration word. Bit 4 sets the direction of port A, bit 1 port B, bit 3 the upper nibble of C and bit 0 the lower nibble of C, with 1 = input. An input line's output enable is 0 and an output line's is 1 from the next clock edge.
- R3: A configuration word copies bits 6:5 to `grp_a_mode` and bit 2 to `grp_b_mode`.
- R4: A configuration word clears the port A, B and C output latches to 0.
- R5: A write to offset 0, 1 or 2 loads the written byte into that port's output latch. The latch drives the port's output pins and holds its value until the next write to that port.
- R6: A read of a port or nibble configured as input returns the present pin values. Nothing is latched, so a change on the pins is seen by the next read.
- R7: A read of a port configured as output returns its latch contents, whatever the pins carry.
- R8: Port C reads combine the two nibbles independently: each nibble returns its pins or its latch according to its own direction.
- R9: A write to offset 3 with bit 7 = 0 is a single-bit command. Bits 3:1 select port C line 0 to 7 and bit 0 is the new value (1 = set, 0 = clear). Only that latch bit changes; directions, modes and ports A and B are left unchanged.
- R10: A read of offset 3 returns 0xFF.
- R11: `rdata` is 0 whenever `rd_stb` is low.
- R12: Writing 0x80 to offset 3 makes all 24 lines outputs with both groups in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register offset: 0 = A, 1 = B, 2 = C, 3 = control |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe, sampled on the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational while rd_stb is high |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables, one 4-bit group per nibble |
| grp_a_mode | output | 2 | Mode requested for group A |
| grp_b_mode | output | 1 | Mode requested for group B |

## Verification
The embedded properties check on every cycle the following. A configuration word leaves all latches at zero and sets the port A enables from its direction bit. A single-bit command flips at most one port C latch bit and leaves every enable and mode pin alone. With no write, the latches and enables do not move. Only the directed scenarios can show the following. The exact field positions of the command words are correct. Port C mixes pins and latch per nibble. Input reads follow pins that change between reads, and the control offset reads back as all ones.

// File: rtl/pio_pkg.sv
package pio_pkg;

  typedef enum logic [1:0] {
    OFS_A    = 2'd0,
    OFS_B    = 2'd1,
    OFS_C    = 2'd2,
    OFS_CTRL = 2'd3
  } pio_ofs_e;

  // Decoded configuration state; *_in = 1 means the lines are inputs.
  typedef struct packed {
    logic [1:0] a_mode;
    logic       b_mode;
    logic       a_in;
    logic       chi_in;
    logic       b_in;
    logic       clo_in;
  } pio_cfg_t;

  localparam pio_cfg_t CFG_RESET = '{a_mode: 2'b00, b_mode: 1'b0,
                                     a_in: 1'b1, chi_in: 1'b1,
                                     b_in: 1'b1, clo_in: 1'b1};

endpackage

// File: rtl/pio_ctl_decode.sv
module pio_ctl_decode
  import pio_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int SEL_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [DATA_W-1:0] wdata,
  output pio_cfg_t          cfg,
  output logic              mode_set,
  output logic              bsr_en,
  output logic [SEL_W-1:0]  bsr_idx,
  output logic              bsr_val
);

  assign mode_set = ctl_wr &  wdata[DATA_W-1];
  assign bsr_en   = ctl_wr & ~wdata[DATA_W-1];
  assign bsr_idx  = wdata[SEL_W:1];
  assign bsr_val  = wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= CFG_RESET;
    end else if (mode_set) begin
      cfg.a_mode <= wdata[6:5];
      cfg.a_in   <= wdata[4];
      cfg.chi_in <= wdata[3];
      cfg.b_mode <= wdata[2];
      cfg.b_in   <= wdata[1];
      cfg.clo_in <= wdata[0];
    end
  end

  // R9
  bsr_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_en |=> $stable(cfg));

endmodule

// File: rtl/pio_out_latch.sv
module pio_out_latch #(
  parameter int W     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [W-1:0]     wr_data,
  input  logic             bit_en,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             bit_val,
  output logic [W-1:0]     q
);

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (clr)    q <= '0;
    else if (wr_en)  q <= wr_data;
    else if (bit_en) q[bit_idx] <= bit_val;
  end

  // R4
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));

  // R9
  single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !clr && !wr_en) |=> ($countones(q ^ $past(q)) <= 1));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !wr_en && !bit_en) |=> $stable(q));

endmodule

// File: rtl/pio_read_mux.sv
module pio_read_mux
  import pio_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int NIB_W = DATA_W / 2
) (
  input  logic              rd_stb,
  input  logic [1:0]        addr,
  input  pio_cfg_t          cfg,
  input  logic [DATA_W-1:0] pa_in,
  input  logic [DATA_W-1:0] pa_q,
  input  logic [DATA_W-1:0] pb_in,
  input  logic [DATA_W-1:0] pb_q,
  input  logic [DATA_W-1:0] pc_in,
  input  logic [DATA_W-1:0] pc_q,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] pc_view;
  logic [1:0]        nib_in;

  assign nib_in = {cfg.chi_in, cfg.clo_in};

  for (genvar n = 0; n < 2; n++) begin : g_nib
    assign pc_view[n*NIB_W +: NIB_W] =
      nib_in[n] ? pc_in[n*NIB_W +: NIB_W] : pc_q[n*NIB_W +: NIB_W];
  end

  always_comb begin
    rdata = '0;
    if (rd_stb) begin
      unique case (addr)
        OFS_A:   rdata = cfg.a_in ? pa_in : pa_q;
        OFS_B:   rdata = cfg.b_in ? pb_in : pb_q;
        OFS_C:   rdata = pc_view;
        default: rdata = '1;
      endcase
    end
  end

endmodule

// File: rtl/pio_triport.sv
module pio_triport
  import pio_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int NIB_W = DATA_W / 2,
  localparam int SEL_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] pa_in,
  output logic [DATA_W-1:0] pa_out,
  output logic [DATA_W-1:0] pa_oe,
  input  logic [DATA_W-1:0] pb_in,
  output logic [DATA_W-1:0] pb_out,
  output logic [DATA_W-1:0] pb_oe,
  input  logic [DATA_W-1:0] pc_in,
  output logic [DATA_W-1:0] pc_out,
  output logic [DATA_W-1:0] pc_oe,
  output logic [1:0]        grp_a_mode,
  output logic              grp_b_mode
);

  pio_cfg_t         cfg;
  logic             mode_set, bsr_en, bsr_val;
  logic [SEL_W-1:0] bsr_idx;
  logic             wr_a, wr_b, wr_c, wr_ctl;
  logic [1:0]       nib_in;

  assign wr_a   = wr_stb && (addr == OFS_A);
  assign wr_b   = wr_stb && (addr == OFS_B);
  assign wr_c   = wr_stb && (addr == OFS_C);
  assign wr_ctl = wr_stb && (addr == OFS_CTRL);

  pio_ctl_decode #(.DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(wr_ctl), .wdata(wdata),
    .cfg(cfg), .mode_set(mode_set), .bsr_en(bsr_en),
    .bsr_idx(bsr_idx), .bsr_val(bsr_val)
  );

  pio_out_latch #(.W(DATA_W), .IDX_W(SEL_W)) u_lat_a (
    .clk(clk), .rst_n(rst_n), .clr(mode_set), .wr_en(wr_a), .wr_data(wdata),
    .bit_en(1'b0), .bit_idx('0), .bit_val(1'b0), .q(pa_out)
  );

  pio_out_latch #(.W(DATA_W), .IDX_W(SEL_W)) u_lat_b (
    .clk(clk), .rst_n(rst_n), .clr(mode_set), .wr_en(wr_b), .wr_data(wdata),
    .bit_en(1'b0), .bit_idx('0), .bit_val(1'b0), .q(pb_out)
  );

  pio_out_latch #(.W(DATA_W), .IDX_W(SEL_W)) u_lat_c (
    .clk(clk), .rst_n(rst_n), .clr(mode_set), .wr_en(wr_c), .wr_data(wdata),
    .bit_en(bsr_en), .bit_idx(bsr_idx), .bit_val(bsr_val), .q(pc_out)
  );

  assign pa_oe = {DATA_W{~cfg.a_in}};
  assign pb_oe = {DATA_W{~cfg.b_in}};
  assign nib_in = {cfg.chi_in, cfg.clo_in};

  for (genvar n = 0; n < 2; n++) begin : g_c_oe
    assign pc_oe[n*NIB_W +: NIB_W] = {NIB_W{~nib_in[n]}};
  end

  assign grp_a_mode = cfg.a_mode;
  assign grp_b_mode = cfg.b_mode;

  pio_read_mux #(.DATA_W(DATA_W)) u_rd (
    .rd_stb(rd_stb), .addr(addr), .cfg(cfg),
    .pa_in(pa_in), .pa_q(pa_out), .pb_in(pb_in), .pb_q(pb_out),
    .pc_in(pc_in), .pc_q(pc_out), .rdata(rdata)
  );

  // R4
  cfg_clears_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && addr == 2'd3 && wdata[7]) |=>
      (pa_out == '0 && pb_out == '0 && pc_out == '0));

  // R2
  port_a_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && addr == 2'd3 && wdata[7]) |=>
      (pa_oe == {DATA_W{~$past(wdata[4])}}));

  // R9
  bsr_keeps_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && addr == 2'd3 && !wdata[7]) |=>
      ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe) &&
       $stable(pa_out) && $stable(pb_out) && $stable(grp_a_mode) &&
       $stable(grp_b_mode)));

  // R5
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
                 $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

endmodule

// File: tb/tb_pio_triport.sv
module tb_pio_triport;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       rd_stb = 1'b0, wr_stb = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  logic [1:0] grp_a_mode;
  logic       grp_b_mode;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pio_triport dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe),
    .grp_a_mode(grp_a_mode), .grp_b_mode(grp_b_mode)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0;
    #1;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_stb = 1'b1;
    #1 d = rdata;
    rd_stb = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 pa_oe", pa_oe, 8'h00);
    check("R1 pb_oe", pb_oe, 8'h00);
    check("R1 pc_oe", pc_oe, 8'h00);
    check("R1 latches", pa_out | pb_out | pc_out, 8'h00);
    check("R1 modes", {5'b0, grp_a_mode, grp_b_mode}, 8'h00);
    pa_in = 8'h3C;
    bus_read(2'd0, v);
    check("R1 R6 port A input read", v, 8'h3C);
  endtask

  task automatic t_all_out();
    logic [7:0] v;
    bus_write(2'd3, 8'h80);
    check("R12 pa_oe", pa_oe, 8'hFF);
    check("R12 pb_oe", pb_oe, 8'hFF);
    check("R12 pc_oe", pc_oe, 8'hFF);
    check("R12 modes", {5'b0, grp_a_mode, grp_b_mode}, 8'h00);
    bus_write(2'd0, 8'h12);
    bus_write(2'd1, 8'h34);
    bus_write(2'd2, 8'h56);
    check("R5 pa_out", pa_out, 8'h12);
    check("R5 pb_out", pb_out, 8'h34);
    check("R5 pc_out", pc_out, 8'h56);
    pa_in = 8'hEE; pb_in = 8'h11; pc_in = 8'h99;
    bus_read(2'd0, v); check("R7 read A latch", v, 8'h12);
    bus_read(2'd1, v); check("R7 read B latch", v, 8'h34);
    bus_read(2'd2, v); check("R7 read C latch", v, 8'h56);
  endtask

  task automatic t_cfg_clear();
    bus_write(2'd3, 8'h80);
    check("R4 pa_out cleared", pa_out, 8'h00);
    check("R4 pb_out cleared", pb_out, 8'h00);
    check("R4 pc_out cleared", pc_out, 8'h00);
  endtask

  task automatic t_mixed_c();
    logic [7:0] v;
    // 0x88: C upper nibble input (bit 3), all else output
    bus_write(2'd3, 8'h88);
    check("R2 R8 pc_oe split", pc_oe, 8'h0F);
    check("R2 pa_oe", pa_oe, 8'hFF);
    bus_write(2'd2, 8'hA5);
    pc_in = 8'h3C;
    bus_read(2'd2, v); check("R8 C mixed read", v, 8'h35);
    pc_in = 8'hC0;
    bus_read(2'd2, v); check("R6 R8 C live upper", v, 8'hC5);
    // 0x81: C lower nibble input (bit 0)
    bus_write(2'd3, 8'h81);
    check("R2 pc_oe lower in", pc_oe, 8'hF0);
    bus_write(2'd2, 8'h7B);
    pc_in = 8'h0E;
    bus_read(2'd2, v); check("R8 C lower live", v, 8'h7E);
    // 0x82: port B input (bit 1)
    bus_write(2'd3, 8'h82);
    check("R2 pb_oe input", pb_oe, 8'h00);
    check("R2 pa_oe output", pa_oe, 8'hFF);
  endtask

  task automatic t_modes();
    bus_write(2'd3, 8'hE4);
    check("R3 group A mode 11", {6'b0, grp_a_mode}, 8'h03);
    check("R3 group B mode 1", {7'b0, grp_b_mode}, 8'h01);
    check("R2 all out with modes", pa_oe & pb_oe & pc_oe, 8'hFF);
    bus_write(2'd3, 8'hA0);
    check("R3 group A mode 01", {6'b0, grp_a_mode}, 8'h01);
    check("R3 group B mode 0", {7'b0, grp_b_mode}, 8'h00);
  endtask

  task automatic t_bsr();
    bus_write(2'd3, 8'hA0);
    bus_write(2'd0, 8'h5A);
    bus_write(2'd2, 8'h00);
    bus_write(2'd3, 8'h0B);
    check("R9 set bit5", pc_out, 8'h20);
    bus_write(2'd3, 8'h01);
    check("R9 set bit0", pc_out, 8'h21);
    bus_write(2'd3, 8'h0F);
    check("R9 set bit7", pc_out, 8'hA1);
    bus_write(2'd3, 8'h0A);
    check("R9 clear bit5", pc_out, 8'h81);
    check("R9 port A untouched", pa_out, 8'h5A);
    check("R9 enables unchanged", pa_oe & pb_oe & pc_oe, 8'hFF);
    check("R9 mode unchanged", {6'b0, grp_a_mode}, 8'h01);
  endtask

  task automatic t_ctrl_and_inputs();
    logic [7:0] v;
    bus_read(2'd3, v); check("R10 control reads FF", v, 8'hFF);
    @(negedge clk); addr = 2'd0; #1;
    check("R11 rdata idle", rdata, 8'h00);
    bus_write(2'd3, 8'h9B);
    check("R2 all inputs oe", pa_oe | pb_oe | pc_oe, 8'h00);
    pa_in = 8'h5A; pb_in = 8'h66;
    bus_read(2'd0, v); check("R6 A live 1", v, 8'h5A);
    pa_in = 8'hA5;
    bus_read(2'd0, v); check("R6 A live 2", v, 8'hA5);
    bus_read(2'd1, v); check("R6 B live", v, 8'h66);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_all_out();
    t_cfg_clear();
    t_mixed_c();
    t_modes();
    t_bsr();
    t_ctrl_and_inputs();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule